// File: doc/BRIEF.md
# Infrared Receive Sampler with FIFO

This block turns the output of a consumer infrared receiver into bytes for a host. A 16-bit divisor sets how often the input is sampled. Each sample may first be inverted to match the receiver's output polarity. Eight samples make one byte, with the earliest sample in the most significant bit. Completed bytes go into an eight-entry receive FIFO. The host drains that FIFO through a small synchronous register bus.

Two status flags report activity: a ready flag when a byte has been stored, and a lost flag when a byte arrived while the FIFO was full. Both are cleared by writing 1 to them. A status field shows the FIFO fill level, and a self-clearing control bit empties the FIFO. An interrupt enable gates the two flags onto the interrupt output. A 3-bit protocol select field is stored and driven out unchanged so that a downstream decoder can use it. The block does no protocol decoding of its own.

Register offsets on `addr`: 0 data, 1 interrupt enable, 2 status, 3 divisor low byte, 4 divisor high byte, 5 control. Offsets 6 and 7 are unused.

Top module: `ir_rx_sampler`

## Requirements
- R1: The FIFO holds up to 8 bytes. A read at offset 0 returns the oldest byte and removes it. A read at offset 0 with the FIFO empty returns 0x00 and removes nothing.
- R2: Status bits [7:4] hold the number of bytes in the FIFO, from 0 to 8.
- R3: Writing 1 to status bit 3 empties the FIFO. That bit always reads 0. A byte that completes in the same cycle is dropped without setting any flag. A partly assembled byte is not affected.
- R4: Status bit 1 (lost) is set when a byte completes while the FIFO already holds 8 bytes. That byte is discarded. A read of offset 0 in the same cycle does not make room for it. Writing 1 to bit 1 clears the flag, and a new loss in the same cycle wins over the clear.
- R5: Status bit 0 (ready) is set when a byte enters the FIFO. Writing 1 to bit 0 clears it, and a new byte in the same cycle wins over the clear.
- R6: The divisor is 16 bits wide: offset 3 holds the low byte (reset 0xA5) and offset 4 the high byte (reset 0x01). A counter that starts at 0 after reset steps by 1 on every clock. In a cycle where the counter is greater than or equal to the divisor, a sample is taken and the counter returns to 0. A written divisor applies from the next cycle.
- R7: Eight consecutive samples form one byte. The first sample lands in bit 7 and the eighth in bit 0.
- R8: Control bit 7 (reset 1) selects inversion: the sampled bit is `ir_in` XOR that control bit.
- R9: Control bits [2:0] (reset 3'b001) are stored, read back and driven on `proto_sel`. They have no effect on sampling.
- R10: `irq` is high exactly when bit 7 at offset 1 (reset 0) is set and either the ready flag or the lost flag is set.
- R11: `rdata` is registered. It shows the addressed value, as it stood before that cycle's updates, in the cycle after `rd_en`, and it holds its value otherwise. Unused bits and offsets 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Receiver output, synchronous to clk |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Receive interrupt |
| proto_sel | output | 3 | Stored protocol select |

## Verification
The hardest case to reach is a byte completing in the same cycle as a host action: a FIFO flush, a pop from a full FIFO, or a write-one-to-clear of the flag that the byte sets. Seen from the ports, these collisions depend on the hidden phase of the divisor counter and the bit counter. The bench therefore keeps a cycle-accurate reference model of both counters. It runs long random phases with divisors of 0 to 15 and random register traffic, so these collisions occur many times. Directed sequences then overfill the FIFO at divisor 0, and fix the input level to check inversion.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_DATA   = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_DIVLO  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_DIVHI  = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 3'd5;

    localparam int unsigned ST_READY = 0;
    localparam int unsigned ST_LOST  = 1;
    localparam int unsigned ST_FLUSH = 3;
    localparam int unsigned IEN_BIT  = 7;
    localparam int unsigned INV_BIT  = 7;

    localparam logic [15:0] DIV_RESET   = 16'h01A5;
    localparam logic [2:0]  PROTO_RESET = 3'b001;
    localparam logic        INV_RESET   = 1'b1;
endpackage

// File: rtl/ir_rx_shifter.sv
module ir_rx_shifter #(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic [DIV_W-1:0]  div,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int unsigned NB_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [DIV_W-1:0]  cnt;
        logic [BYTE_W-1:0] shift;
        logic [NB_W-1:0]   nbits;
    } shf_t;

    shf_t q, d;
    logic tick;

    always_comb begin
        d         = q;
        tick      = (q.cnt >= div);
        byte_done = 1'b0;
        byte_val  = {q.shift[BYTE_W-2:0], bit_in};
        if (tick) begin
            d.cnt   = '0;
            d.shift = byte_val;
            d.nbits = q.nbits + 1'b1;
            if (q.nbits == NB_W'(BYTE_W - 1)) begin
                byte_done = 1'b1;
                d.nbits   = '0;
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_tick_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (q.cnt == '0));
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (q.cnt == $past(q.cnt) + 1'b1));
endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    input  logic                       flush,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty,
    output logic                       push_ok
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rp;
        logic [PW-1:0]           wp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;
    logic  pop_ok;

    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign count = q.cnt;
    assign head  = q.mem[q.rp];

    always_comb begin
        d       = q;
        push_ok = push && !full && !flush;
        pop_ok  = pop && !empty && !flush;
        if (flush) begin
            d.rp  = '0;
            d.wp  = '0;
            d.cnt = '0;
        end else begin
            if (push_ok) begin
                d.mem[q.wp] = wdata;
                d.wp        = q.wp + 1'b1;
            end
            if (pop_ok) d.rp = q.rp + 1'b1;
            d.cnt = q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_count_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
    p_flush_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (full && $stable(q.wp)));
endmodule

// File: rtl/ir_rx_sampler.sv
module ir_rx_sampler
    import ir_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic [2:0]        proto_sel
);
    localparam int unsigned DEPTH = 8;
    localparam int unsigned CW    = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              ien;
        logic [15:0]       div;
        logic              inv;
        logic [2:0]        proto;
        logic              ready;
        logic              lost;
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t q, d;

    logic              byte_done, push_ok, full, empty, flush, pop;
    logic [DATA_W-1:0] byte_val, head;
    logic [CW-1:0]     fcount;
    logic [3:0]        cnt4;
    logic [DATA_W-1:0] rd_mux;
    logic              wr_status;

    ir_rx_shifter #(.DIV_W(16), .BYTE_W(DATA_W)) u_shf (
        .clk(clk), .rst_n(rst_n), .bit_in(ir_in ^ q.inv), .div(q.div),
        .byte_done(byte_done), .byte_val(byte_val)
    );

    ir_rx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(byte_done), .wdata(byte_val),
        .pop(pop), .flush(flush), .head(head), .count(fcount),
        .full(full), .empty(empty), .push_ok(push_ok)
    );

    assign cnt4      = 4'(fcount);
    assign wr_status = wr_en && (addr == OFS_STATUS);
    assign flush     = wr_status && wdata[ST_FLUSH];
    assign pop       = rd_en && (addr == OFS_DATA);

    always_comb begin
        case (addr)
            OFS_DATA:   rd_mux = empty ? '0 : head;
            OFS_IEN:    rd_mux = {q.ien, 7'b0};
            OFS_STATUS: rd_mux = {cnt4, 2'b00, q.lost, q.ready};
            OFS_DIVLO:  rd_mux = q.div[7:0];
            OFS_DIVHI:  rd_mux = q.div[15:8];
            OFS_CTRL:   rd_mux = {q.inv, 4'b0, q.proto};
            default:    rd_mux = '0;
        endcase
    end

    always_comb begin
        d = q;
        if (rd_en) d.rdata = rd_mux;
        d.ready = (q.ready && !(wr_status && wdata[ST_READY])) || push_ok;
        d.lost  = (q.lost && !(wr_status && wdata[ST_LOST]))
                  || (byte_done && full && !flush);
        if (wr_en) begin
            case (addr)
                OFS_IEN:   d.ien = wdata[IEN_BIT];
                OFS_DIVLO: d.div[7:0] = wdata;
                OFS_DIVHI: d.div[15:8] = wdata;
                OFS_CTRL: begin
                    d.inv   = wdata[INV_BIT];
                    d.proto = wdata[2:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.div   <= DIV_RESET;
            q.inv   <= INV_RESET;
            q.proto <= PROTO_RESET;
        end else begin
            q <= d;
        end
    end

    assign rdata     = q.rdata;
    assign irq       = q.ien && (q.ready || q.lost);
    assign proto_sel = q.proto;

    p_lost_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.lost) |-> $past(byte_done && full));
    p_ready_on_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> q.ready);
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.ready && !q.lost && !push_ok && !byte_done) |=> !irq || $past(q.lost));
endmodule

// File: tb/sim_ir_rx_sampler.sv
`timescale 1ns/1ps
module sim_ir_rx_sampler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_in = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    logic [2:0] proto_sel;

    int checks = 0, errors = 0, cycles = 0;
    logic ir_rand = 1'b1, ir_const = 1'b0;

    ir_rx_sampler u0 (.clk(clk), .rst_n(rst_n), .ir_in(ir_in), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .irq(irq), .proto_sel(proto_sel));

    always #2 clk = ~clk;

    // reference model state
    logic [15:0] m_cnt, m_div;
    logic [7:0]  m_shift, m_rdata, m_nbyte;
    logic [2:0]  m_nb, m_rp, m_proto;
    logic [3:0]  m_count;
    logic [7:0]  m_mem [8];
    logic        m_inv, m_ien, m_ready, m_lost;
    logic        m_tick, m_done, m_flush, m_full, m_push, m_pop, m_wst;

    function automatic logic [7:0] m_reg(input logic [2:0] a);
        case (a)
            3'd0: return (m_count == 0) ? 8'h00 : m_mem[m_rp];
            3'd1: return {m_ien, 7'b0};
            3'd2: return {m_count, 2'b00, m_lost, m_ready};
            3'd3: return m_div[7:0];
            3'd4: return m_div[15:8];
            3'd5: return {m_inv, 4'b0, m_proto};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_div = 16'h01A5; m_shift = 0; m_rdata = 0; m_nb = 0;
            m_rp = 0; m_count = 0; m_inv = 1; m_ien = 0; m_ready = 0;
            m_lost = 0; m_proto = 3'b001;
        end else begin
            m_tick  = (m_cnt >= m_div);                      // R6
            m_nbyte = {m_shift[6:0], ir_in ^ m_inv};         // R7, R8
            m_done  = m_tick && (m_nb == 3'd7);
            m_wst   = wr_en && addr == 3'd2;
            m_flush = m_wst && wdata[3];
            m_full  = (m_count == 4'd8);
            m_push  = m_done && !m_full && !m_flush;
            m_pop   = rd_en && addr == 3'd0 && m_count != 0 && !m_flush;
            if (rd_en) m_rdata = m_reg(addr);
            m_ready = (m_ready && !(m_wst && wdata[0])) || m_push;
            m_lost  = (m_lost && !(m_wst && wdata[1])) || (m_done && m_full && !m_flush);
            if (m_flush) begin
                m_count = 0; m_rp = 0;
            end else begin
                if (m_push) m_mem[3'(m_rp + m_count[2:0])] = m_nbyte;
                if (m_pop) m_rp = m_rp + 1;
                m_count = m_count + {3'b0, m_push} - {3'b0, m_pop};
            end
            if (wr_en) case (addr)
                3'd1: m_ien = wdata[7];
                3'd3: m_div[7:0] = wdata;
                3'd4: m_div[15:8] = wdata;
                3'd5: begin m_inv = wdata[7]; m_proto = wdata[2:0]; end
                default: ;
            endcase
            if (m_tick) begin
                m_cnt = 0; m_shift = m_nbyte; m_nb = m_nb + 1;
            end else m_cnt = m_cnt + 1;
        end
    end

    always @(negedge clk) ir_in <= ir_rand ? 1'($urandom % 2) : ir_const;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // continuous port checks at the falling edge
    always @(negedge clk) if (rst_n) begin
        check("R10 irq", {7'b0, irq}, {7'b0, m_ien && (m_ready || m_lost)});
        check("R9 proto_sel", {5'b0, proto_sel}, {5'b0, m_proto});
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk); addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        string tag;
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        case (a)
            3'd0: tag = "R1 R7 data";
            3'd2: tag = "R2 R3 R4 R5 status";
            3'd3, 3'd4: tag = "R6 divisor";
            3'd5: tag = "R8 R9 control";
            default: tag = "R11 register";
        endcase
        check(tag, rdata, m_rdata);
        v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected at most 200000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240517));
        idle(3);
        rst_n = 1'b1;
        // reset state, R11 unused offsets
        rd(3'd3, v); check("R6 reset lo", v, 8'hA5);
        rd(3'd4, v); check("R6 reset hi", v, 8'h01);
        rd(3'd5, v); check("R8 R9 reset ctrl", v, 8'h81);
        rd(3'd1, v); check("R10 reset ien", v, 8'h00);
        rd(3'd6, v); check("R11 offset 6", v, 8'h00);
        rd(3'd7, v); check("R11 offset 7", v, 8'h00);
        idle(2); check("R11 rdata holds", rdata, 8'h00);

        // overflow at divisor 0 (R4)
        wr(3'd4, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h80);
        idle(100);
        rd(3'd2, v); check("R2 R4 full and lost", v & 8'hF2, 8'h82);
        wr(3'd2, 8'h02);
        rd(3'd2, v);
        // drain all (R1), then empty read returns 0
        wr(3'd3, 8'h0F);
        for (int i = 0; i < 9; i++) rd(3'd0, v);
        wr(3'd2, 8'h08); rd(3'd0, v); check("R1 empty read", v, 8'h00);
        rd(3'd2, v); check("R3 flush bit reads 0", v & 8'h08, 8'h00);

        // inversion with constant input (R8)
        ir_rand = 1'b0; ir_const = 1'b1;
        wr(3'd3, 8'h03); wr(3'd5, 8'h80);
        idle(40); wr(3'd2, 8'h0B); idle(36);
        rd(3'd0, v); check("R8 inverted ones", v, 8'h00);
        wr(3'd5, 8'h05); idle(40); wr(3'd2, 8'h0B); idle(36);
        rd(3'd0, v); check("R7 R8 plain ones", v, 8'hFF);
        ir_rand = 1'b1;

        // random traffic
        for (int i = 0; i < 6000; i++) begin
            int unsigned op = $urandom % 16;
            logic [2:0] a = 3'($urandom % 8);
            logic [7:0] d = 8'($urandom);
            if (op < 8) rd(a, v);
            else if (op < 10) wr(3'd2, d & 8'h0B);
            else if (op == 10) wr(3'd3, d & 8'h0F);
            else if (op == 11) wr(3'd4, 8'h00);
            else if (op == 12) wr(3'd5, d);
            else if (op == 13) wr(3'd1, d);
            else idle(int'($urandom % 20));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule